// File: doc/BRIEF.md
# Supervisory Reset Generator with Stretch

This block merges several reset requests into a single active-low processor reset. Two requests are level flags from external voltage comparators: the main supply flag and a second monitored rail, each high while its rail is above threshold. The third is a manual reset pin. A manual low only counts once it has lasted a qualification time, so short glitches cannot cause a reset. The fourth is a watchdog fault pulse. All inputs are assumed to be synchronous to `clk` already.

The output is registered. It goes low on the clock edge that samples any active request and stays low while a request remains. Once every request has cleared, it stays low for a run of clean clock edges set by `stretch_cycles`, then goes high. A new request during that run restarts the count. A status code reports which source opened the most recent reset episode.

Top module: `rst_supervisor`

## Requirements
- R1: `supply_ok` sampled low at a rising edge drives `sys_rst_n` low after that edge, and it stays low while `supply_ok` stays low.
- R2: `aux_ok` sampled low has the same effect as R1, independently of `supply_ok`.
- R3: `man_rst_n` sampled low at MR_QUAL consecutive edges raises an internal manual request. `sys_rst_n` is low after the next edge if the pin is still low at that edge.
- R4: A manual low lasting fewer than MR_QUAL consecutive sampled edges has no effect on `sys_rst_n` or `rst_cause`.
- R5: The last edge that samples an active request is followed by T = `stretch_cycles` clean edges. `sys_rst_n` goes high after the T-th clean edge and no earlier. Releasing a qualified manual reset also starts this count.
- R6: A one-cycle `wdog_fault` pulse holds `sys_rst_n` low for exactly T cycles.
- R7: A request seen during the stretch run discards the partial count. The full T clean edges are needed again after it clears.
- R8: `sys_rst_n` is low while `por_n` is low. After `por_n` rises, release again needs T clean edges.
- R9: `rst_cause` is 0 after power-on reset. An edge that samples a request, with no request at the previous edge, loads `rst_cause` with the highest-priority active source: 1 supply, 2 second rail, 3 manual, 4 watchdog.
- R10: A `stretch_cycles` value of 0 behaves as 1. The output is released after the first clean edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Main supply above threshold when high |
| aux_ok | input | 1 | Second monitored rail above threshold when high |
| man_rst_n | input | 1 | Manual reset pin, active low, filtered |
| wdog_fault | input | 1 | Watchdog fault request, active high |
| stretch_cycles | input | CW | Release delay T in clean clock edges |
| sys_rst_n | output | 1 | Processor reset, active low, registered |
| rst_cause | output | 3 | Source code of the latest reset episode |

## Verification
The stretch logic is driven by each source on its own: a held supply low, a held second-rail low, a qualified manual press and a single watchdog pulse. Each one separates the request latency from the release count. The manual pin also gets lows one cycle and one edge short of qualification, which show that the filter drops them rather than delaying them. A request landing mid-stretch shows whether the count restarts, and simultaneous requests expose the cause priority. A zero timeout and power-on release cover both ends of the counter.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int CW      = 16,
  parameter int MR_QUAL = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          supply_ok,
  input  logic          aux_ok,
  input  logic          man_rst_n,
  input  logic          wdog_fault,
  input  logic [CW-1:0] stretch_cycles,
  output logic          sys_rst_n,
  output logic [2:0]    rst_cause
);
  localparam int            QW     = $clog2(MR_QUAL + 1);
  localparam logic [QW-1:0] QMAX   = QW'(MR_QUAL);
  localparam logic [2:0]    C_POR  = 3'd0;
  localparam logic [2:0]    C_SUP  = 3'd1;
  localparam logic [2:0]    C_AUX  = 3'd2;
  localparam logic [2:0]    C_MAN  = 3'd3;
  localparam logic [2:0]    C_WDG  = 3'd4;

  logic [QW-1:0] mr_cnt;
  logic [CW-1:0] hold;
  logic          man_req, req_any, req_q, done;
  logic [2:0]    pick;

  assign man_req = (mr_cnt == QMAX);
  assign req_any = !supply_ok || !aux_ok || man_req || wdog_fault;
  assign done    = ({1'b0, hold} + (CW+1)'(1)) >= {1'b0, stretch_cycles};
  assign pick    = !supply_ok ? C_SUP :
                   !aux_ok    ? C_AUX :
                   man_req    ? C_MAN : C_WDG;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          mr_cnt <= '0;
    else if (man_rst_n)  mr_cnt <= '0;
    else if (!man_req)   mr_cnt <= mr_cnt + QW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sys_rst_n <= 1'b0;
      hold      <= '0;
      req_q     <= 1'b0;
      rst_cause <= C_POR;
    end else begin
      req_q <= req_any;
      if (req_any) begin
        sys_rst_n <= 1'b0;
        hold      <= '0;
        if (!req_q) rst_cause <= pick;
      end else if (!sys_rst_n) begin
        if (done) begin
          sys_rst_n <= 1'b1;
          hold      <= '0;
        end else begin
          hold <= hold + CW'(1);
        end
      end
    end
  end

  p_req_pulls_low_r1: assert property (@(posedge clk) disable iff (!por_n)
    req_any |=> !sys_rst_n);
  p_rise_needs_quiet_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> !$past(req_any));
  p_fall_needs_req_r6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst_n) |-> $past(req_any));
  p_mr_release_clears_r4: assert property (@(posedge clk) disable iff (!por_n)
    man_rst_n |=> !man_req);
  p_mr_qualified_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(man_req) |-> $past(!man_rst_n));
  p_cause_loaded_r9: assert property (@(posedge clk) disable iff (!por_n)
    (req_any && !req_q) |=> (rst_cause != C_POR));
  p_cause_range_r9: assert property (@(posedge clk) disable iff (!por_n)
    rst_cause <= C_WDG);
endmodule

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 16;
  localparam int QUAL       = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          por_n = 1'b0, supply_ok = 1'b1, aux_ok = 1'b1;
  logic          man_rst_n = 1'b1, wdog_fault = 1'b0;
  logic [CW-1:0] stretch_cycles = CW'(5);
  logic          sys_rst_n;
  logic [2:0]    rst_cause;

  rst_supervisor #(.CW(CW), .MR_QUAL(QUAL)) dut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .aux_ok(aux_ok),
    .man_rst_n(man_rst_n), .wdog_fault(wdog_fault),
    .stretch_cycles(stretch_cycles), .sys_rst_n(sys_rst_n), .rst_cause(rst_cause));

  typedef struct {int due; logic rst; logic [2:0] cause; string tag;} exp_t;
  exp_t sbq[$];
  int cyc = 0, checks = 0, errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(logic r, logic [2:0] c, string tag);
    checks++;
    if (sys_rst_n !== r || rst_cause !== c) begin
      errors++;
      $display("FAIL %s: sys_rst_n=%0b cause=%0d expected sys_rst_n=%0b cause=%0d",
               tag, sys_rst_n, rst_cause, r, c);
    end
  endtask

  always @(posedge clk) begin
    #3;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t it;
      it = sbq.pop_front();
      check(it.rst, it.cause, it.tag);
    end
  end

  task automatic run(int n, logic s, logic a, logic m, logic w,
                     logic e, logic [2:0] c, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      supply_ok = s; aux_ok = a; man_rst_n = m; wdog_fault = w;
      sbq.push_back('{cyc + 1, e, c, tag});
    end
  endtask

  task automatic idle(int n, logic e, logic [2:0] c, string tag);
    run(n, 1'b1, 1'b1, 1'b1, 1'b0, e, c, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1'b0, 3'd0, "R8 reset state");
    por_n = 1'b1;
    idle(3, 1'b0, 3'd0, "R8 held after por");
    idle(2, 1'b1, 3'd0, "R8 release");
    run(3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, "R1 supply low");
    idle(4, 1'b0, 3'd1, "R5 stretch");
    idle(2, 1'b1, 3'd1, "R5 release");
    run(2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, "R2 aux low");
    idle(4, 1'b0, 3'd2, "R2 stretch");
    idle(2, 1'b1, 3'd2, "R2 release");
    run(8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, "R3 qualifying");
    run(2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, "R3 manual");
    idle(5, 1'b0, 3'd3, "R5 manual release");
    idle(2, 1'b1, 3'd3, "R5 manual release");
    run(7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, "R4 short low");
    idle(3, 1'b1, 3'd3, "R4 ignored");
    run(1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, "R4 glitch");
    idle(2, 1'b1, 3'd3, "R4 glitch ignored");
    run(1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, "R6 watchdog");
    idle(4, 1'b0, 3'd4, "R6 pulse width");
    idle(2, 1'b1, 3'd4, "R6 release");
    run(1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, "R7 first");
    idle(3, 1'b0, 3'd1, "R7 partial");
    run(1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, "R7 reassert");
    idle(4, 1'b0, 3'd2, "R7 restart");
    idle(2, 1'b1, 3'd2, "R7 release");
    run(1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, "R9 priority supply");
    idle(4, 1'b0, 3'd1, "R9 stretch");
    idle(2, 1'b1, 3'd1, "R9 release");
    run(1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, "R9 priority aux");
    idle(4, 1'b0, 3'd2, "R9 stretch");
    idle(2, 1'b1, 3'd2, "R9 release");
    stretch_cycles = '0;
    run(1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd4, "R10 zero timeout");
    idle(2, 1'b1, 3'd4, "R10 release");
    repeat (3) @(posedge clk);
    #5;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule